// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block sits behind an external dual-modulus prescaler and turns the prescaled clock into the divided feedback signal for a phase detector. Its clock is the prescaler output. Two down-counters run side by side: a main counter loaded with N and a swallow counter loaded with A. While the swallow counter still has counts left, the modulus-control line stays low and asks the prescaler to divide by P+1. After that the line goes high and the prescaler divides by P for the rest of the main count. One full cycle of the block therefore spans N·P+A cycles of the oscillator that feeds the prescaler.

Each cycle lasts N prescaled clocks. In the last of those clocks the block raises a one-clock terminal-count strobe, and at the following edge both counters take fresh values from the parallel program inputs. The program inputs are sampled only at that reload edge, so they may be changed at any time without disturbing the cycle that is running. A synchronous active-high reset clears the block. The first cycle then starts at the first rising edge where reset is low.

Top module: `swallow_div_ctrl`

## Requirements
- R1: While `rst` is sampled high, both outputs read 0 after that edge. The first count cycle begins at the first rising edge where `rst` is sampled low.
- R2: Number the clocks of a cycle k = 0..N-1. `mod_ctl` is 0 (prescaler at P+1) for every clock with k < A.
- R3: `mod_ctl` is 1 (prescaler at P) for every clock with A ≤ k ≤ N-1. It falls only at the edge that follows a terminal-count strobe.
- R4: With A = 0, `mod_ctl` is 1 for all N clocks of the cycle, starting with k = 0.
- R5: `tc_pulse` is 1 only in clock k = N-1, so it is one clock wide and repeats every N clocks.
- R6: N and A are taken from `n_prog` and `a_prog` only at the reload edge after a strobe, or at the first edge after reset. A change at any other time has no effect on the cycle in progress.
- R7: Over one cycle, (number of clocks with `mod_ctl` = 0)·(P+1) + (number with `mod_ctl` = 1)·P equals N·P+A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled input clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| n_prog | input | N_W (10) | Main count N, valid range 3..1023 |
| a_prog | input | A_W (6) | Swallow count A, valid range 0..63 and not above N |
| mod_ctl | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| tc_pulse | output | 1 | One-clock terminal-count strobe, the divided feedback |

## Verification
The assertions assume that every value presented at a reload edge has N of at least 3 and A no larger than N. With N below 3, the strobe could repeat on consecutive clocks or never appear. With A above N, the swallow counter would still be running when the cycle ends. The stimulus only ever sets the program inputs to such pairs, including the edge pairs N = A = 3, A = 0 and N = 1023 with A = 63. It changes them on the second clock of each cycle, well clear of the reload edge. Reset is also raised in the middle of a cycle, and the inputs are only updated while it is held.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int unsigned DEF_N_W = 10;
    localparam int unsigned DEF_A_W = 6;
endpackage

// File: rtl/swd_main_cnt.sv
module swd_main_cnt #(
    parameter int unsigned W = swd_pkg::DEF_N_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] load_val,
    output logic         reload_o,
    output logic         tc_o
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tc;
    } st_t;

    st_t s_d, s_q;

    // A count of 0 only exists straight after reset; 1 is the last clock.
    assign reload_o = (s_q.cnt <= ONE);
    assign tc_o     = s_q.tc;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d = '0;
        end else if (reload_o) begin
            s_d.cnt = load_val;
            s_d.tc  = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt - ONE;
            s_d.tc  = (s_q.cnt == TWO);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end
endmodule

// File: rtl/swd_swallow_cnt.sv
module swd_swallow_cnt #(
    parameter int unsigned W = swd_pkg::DEF_A_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic         mod_o
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         mod;
    } st_t;

    st_t s_d, s_q;

    assign mod_o = s_q.mod;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d = '0;
        end else begin
            if (reload) begin
                s_d.cnt = load_val;
            end else if (s_q.cnt != ZERO) begin
                s_d.cnt = s_q.cnt - ONE;
            end
            s_d.mod = (s_d.cnt == ZERO);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end
endmodule

// File: rtl/swallow_div_ctrl.sv
module swallow_div_ctrl #(
    parameter int unsigned N_W = swd_pkg::DEF_N_W,
    parameter int unsigned A_W = swd_pkg::DEF_A_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_W-1:0] n_prog,
    input  logic [A_W-1:0] a_prog,
    output logic           mod_ctl,
    output logic           tc_pulse
);
    logic reload;

    swd_main_cnt #(.W(N_W)) u_main (
        .clk      (clk),
        .rst      (rst),
        .load_val (n_prog),
        .reload_o (reload),
        .tc_o     (tc_pulse)
    );

    swd_swallow_cnt #(.W(A_W)) u_swal (
        .clk      (clk),
        .rst      (rst),
        .reload   (reload),
        .load_val (a_prog),
        .mod_o    (mod_ctl)
    );
endmodule

// File: rtl/swd_checker.sv
module swd_checker #(
    parameter int unsigned N_W = swd_pkg::DEF_N_W,
    parameter int unsigned A_W = swd_pkg::DEF_A_W
) (
    input logic           clk,
    input logic           rst,
    input logic [N_W-1:0] n_prog,
    input logic [A_W-1:0] a_prog,
    input logic           mod_ctl,
    input logic           tc_pulse
);
    localparam int unsigned LW = N_W + 1;

    logic          armed_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] snap_q;

    // Track the position in the cycle and the N taken at its start.
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            len_q   <= '0;
            snap_q  <= '0;
        end else if (!armed_q || tc_pulse) begin
            armed_q <= 1'b1;
            len_q   <= LW'(1);
            snap_q  <= LW'(n_prog);
        end else begin
            len_q   <= len_q + LW'(1);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!mod_ctl && !tc_pulse)); // R1

    AST_MOD_FALLS_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ($fell(mod_ctl) && !$past(rst)) |-> $past(tc_pulse)); // R3

    AST_ZERO_SWALLOW_HIGH: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse && (a_prog == '0)) |=> mod_ctl); // R4

    AST_STROBE_AT_END: assert property (@(posedge clk) disable iff (rst)
        (armed_q && tc_pulse) |-> (len_q == snap_q)); // R5

    AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !tc_pulse) |-> (len_q < snap_q)); // R6

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        tc_pulse |=> !tc_pulse); // R5
endmodule

bind swallow_div_ctrl swd_checker #(.N_W(N_W), .A_W(A_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .n_prog   (n_prog),
    .a_prog   (a_prog),
    .mod_ctl  (mod_ctl),
    .tc_pulse (tc_pulse)
);

// File: tb/tb_swallow_div_ctrl.sv
module tb_swallow_div_ctrl;
    localparam int P = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] n_prog = 10'd3;
    logic [5:0] a_prog = 6'd0;
    logic       mod_ctl, tc_pulse;

    swallow_div_ctrl dut (
        .clk(clk), .rst(rst), .n_prog(n_prog), .a_prog(a_prog),
        .mod_ctl(mod_ctl), .tc_pulse(tc_pulse)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic  mod;
        logic  tc;
        string tag;
        int    total;
    } item_t;

    item_t exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    mon_en   = 1'b0;
    bit    done     = 1'b0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Driver side: expected outputs for one full cycle.
    task automatic push_period(int n, int a);
        for (int k = 0; k < n; k++) begin
            item_t it;
            it.mod   = (k >= a);
            it.tc    = (k == n - 1);
            it.total = (k == n - 1) ? n * P + a : -1;
            if (k == n - 1)   it.tag = "R5";
            else if (a == 0)  it.tag = "R4";
            else if (k < a)   it.tag = "R2/R6";
            else              it.tag = "R3";
            exp_q.push_back(it);
        end
    endtask

    // Step through one cycle; new program values appear mid-cycle (R6).
    task automatic play_period(int n, int nn, int na, bit push_next);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k == 1) begin
                n_prog = 10'(nn);
                a_prog = 6'(na);
            end
            if (k == n - 1 && push_next) push_period(nn, na);
        end
    endtask

    // Monitor: pops one expected item per clock, checks the R7 total per cycle.
    int lo_cnt = 0;
    int hi_cnt = 0;
    always @(posedge clk) begin
        #2;
        if (!mon_en) begin
            lo_cnt = 0;
            hi_cnt = 0;
        end else if (exp_q.size() == 0) begin
            check(1'b0, "R5", "unexpected clock, queue empty", 0, 1);
        end else begin
            item_t it;
            it = exp_q.pop_front();
            check(mod_ctl === it.mod, it.tag, "mod_ctl", int'(mod_ctl), int'(it.mod));
            check(tc_pulse === it.tc, it.tag, "tc_pulse", int'(tc_pulse), int'(it.tc));
            if (mod_ctl) hi_cnt++; else lo_cnt++;
            if (it.total >= 0) begin
                check(lo_cnt * (P + 1) + hi_cnt * P == it.total, "R7", "total division",
                      lo_cnt * (P + 1) + hi_cnt * P, it.total);
                lo_cnt = 0;
                hi_cnt = 0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R5", "watchdog expired", 0, 1);
            report();
        end
    end

    int cfg_n [8] = '{3, 3, 10, 7, 1023, 5, 20, 64};
    int cfg_a [8] = '{0, 3, 4, 0, 63, 5, 1, 63};

    initial begin
        n_prog = 10'(cfg_n[0]);
        a_prog = 6'(cfg_a[0]);
        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        check(mod_ctl === 1'b0, "R1", "mod_ctl in reset", int'(mod_ctl), 0);
        check(tc_pulse === 1'b0, "R1", "tc_pulse in reset", int'(tc_pulse), 0);
        rst = 1'b0;
        push_period(cfg_n[0], cfg_a[0]);
        mon_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i < 7) play_period(cfg_n[i], cfg_n[i+1], cfg_a[i+1], 1'b1);
            else       play_period(cfg_n[i], cfg_n[i], cfg_a[i], 1'b0);
        end
        mon_en = 1'b0;
        // Reset in the middle of a cycle (R1).
        repeat (3) @(negedge clk);
        rst = 1'b1;
        exp_q.delete();
        repeat (2) begin
            @(negedge clk);
            check(mod_ctl === 1'b0, "R1", "mod_ctl after mid reset", int'(mod_ctl), 0);
            check(tc_pulse === 1'b0, "R1", "tc_pulse after mid reset", int'(tc_pulse), 0);
        end
        n_prog = 10'd5;
        a_prog = 6'd2;
        @(negedge clk);
        rst = 1'b0;
        push_period(5, 2);
        mon_en = 1'b1;
        play_period(5, 5, 2, 1'b1);
        play_period(5, 5, 2, 1'b0);
        mon_en = 1'b0;
        check(exp_q.size() == 0, "R5", "leftover expected items", exp_q.size(), 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        report();
    end
endmodule